// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock level for an I2C master from a fast peripheral clock. A programmable divider value sets the length of one timing unit (divider + 1 peripheral cycles). A two-bit ratio selector picks how many units form the low half and how many form the high half of each SCL period. Every period also carries four extra peripheral cycles: two go to the low half and two to the high half. A full period therefore lasts (lowUnits + highUnits) * (divider + 1) + 4 cycles.

Next to the SCL level, the block gives two one-cycle strobes. One marks the first cycle of each low half and the other marks the first cycle of each high half, so that neighbouring logic can time SDA changes and sampling. Divider, ratio and slave-mode inputs are captured only when a period starts, so a change made part way through a period leaves that period alone. In slave mode a divider of zero is raised to one. While the enable is low, SCL is released (high) and all counting stops.

Top module: `scl_ratio_div`

## Requirements
- R1: With ratioSel = 0 and effective divider D, each low half lasts 4*(D+1)+2 cycles and each high half lasts 4*(D+1)+2 cycles.
- R2: With ratioSel = 1, each low half lasts 6*(D+1)+2 cycles and each high half lasts 3*(D+1)+2 cycles.
- R3: With ratioSel = 2, each low half lasts 11*(D+1)+2 cycles and each high half lasts 3*(D+1)+2 cycles.
- R4: ratioSel = 3 gives the same half lengths as ratioSel = 0.
- R5: When slaveMode = 1 and divVal = 0, the effective divider is 1. In every other case the effective divider equals divVal, including divVal = 0 when slaveMode = 0.
- R6: divVal, ratioSel and slaveMode are sampled at the clock edge that starts a low half. A change made during a period has no effect on that period's low or high half.
- R7: While enable = 0, and out of reset, sclOut = 1 and both strobes are 0. When enable is sampled high from the disabled state, the next cycle is the first cycle of a full-length low half.
- R8: lowStart is 1 for exactly the first cycle of each low half, in which sclOut = 0. highStart is 1 for exactly the first cycle of each high half, in which sclOut = 1. The two strobes are never 1 together.
- R9: Every period is one low half followed by one high half. sclOut does not change inside a half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the generator when high; releases SCL when low |
| divVal | input | DIV_W | Divider value; one unit lasts effective divider + 1 cycles |
| ratioSel | input | 2 | Low/high unit selector (0: 4/4, 1: 6/3, 2: 11/3, 3: 4/4) |
| slaveMode | input | 1 | Raises a zero divider to one when high |
| sclOut | output | 1 | SCL level to drive (0 = pull low, 1 = release) |
| lowStart | output | 1 | One-cycle strobe on the first cycle of a low half |
| highStart | output | 1 | One-cycle strobe on the first cycle of a high half |

## Verification
The assertions assume that inputs change only between clock edges and that reset is asserted from the first cycle. They assume nothing about when the configuration changes: any value on any cycle is allowed, and the minimum slave-mode low length is checked against whatever divider and ratio were present at the period start. The stimulus changes the configuration only in the first cycle of a low half. This lets the scoreboard tell exactly which period runs on the old settings and which on the new, and it also tests that a change made inside a period does not alter that period. Disabling is done part way through a low half, where a release that comes too late or a strobe that is left over shows up at once.

// File: rtl/scl_ratio_div_pkg.sv
package scl_ratio_div_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phaseT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLow;   // period begins: capture config, load low length
    logic loadHigh;  // low half over: load captured high length
    logic clear;     // disabled: zero the counter
  } ctlStrobesT;

  function automatic logic [3:0] lowUnits(input logic [1:0] sel);
    case (sel)
      2'd1:    lowUnits = 4'd6;
      2'd2:    lowUnits = 4'd11;
      default: lowUnits = 4'd4;   // codes 0 and 3
    endcase
  endfunction

  function automatic logic [3:0] highUnits(input logic [1:0] sel);
    case (sel)
      2'd1, 2'd2: highUnits = 4'd3;
      default:    highUnits = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/scl_ratio_div_dp.sv
module scl_ratio_div_dp
  import scl_ratio_div_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = DIV_W + 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobesT       ctl,
  input  logic [DIV_W-1:0] divVal,
  input  logic [1:0]       ratioSel,
  input  logic             slaveMode,
  output logic             phaseDone
);

  logic [DIV_W-1:0] divEff;
  logic [CNT_W-1:0] unitLen;
  logic [CNT_W-1:0] lenLow;
  logic [CNT_W-1:0] lenHigh;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] highLenQ;

  // slave mode forbids a zero divider
  assign divEff  = (slaveMode && (divVal == '0)) ? DIV_W'(1) : divVal;
  assign unitLen = CNT_W'(divEff) + CNT_W'(1);
  assign lenLow  = CNT_W'(lowUnits(ratioSel)) * unitLen + CNT_W'(2);
  assign lenHigh = CNT_W'(highUnits(ratioSel)) * unitLen + CNT_W'(2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= '0;
      highLenQ <= '0;
    end else if (ctl.clear) begin
      cnt      <= '0;
    end else if (ctl.loadLow) begin
      cnt      <= lenLow - CNT_W'(1);
      highLenQ <= lenHigh;
    end else if (ctl.loadHigh) begin
      cnt      <= highLenQ - CNT_W'(1);
    end else if (cnt != '0) begin
      cnt      <= cnt - CNT_W'(1);
    end
  end

  assign phaseDone = (cnt == '0);

  // captured high length only moves at a period start
  AST_HIGH_LEN_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadLow |=> $stable(highLenQ)) else $error("high length changed mid-period"); // R6

  // slave mode: shortest low half is 4 units of 2 cycles plus 2
  AST_SLAVE_MIN_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.loadLow && slaveMode) |=> (cnt >= CNT_W'(9))) else $error("slave low half too short"); // R5

endmodule

// File: rtl/scl_ratio_div_ctl.sv
module scl_ratio_div_ctl
  import scl_ratio_div_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       phaseDone,
  output ctlStrobesT ctl,
  output logic       sclOut,
  output logic       lowStart,
  output logic       highStart
);

  phaseT state;
  phaseT nextState;

  always_comb begin
    nextState = state;
    ctl       = '0;
    case (state)
      PH_IDLE: begin
        if (enable) begin
          nextState   = PH_LOW;
          ctl.loadLow = 1'b1;
        end else begin
          ctl.clear = 1'b1;
        end
      end
      PH_LOW: begin
        if (!enable) begin
          nextState = PH_IDLE;
          ctl.clear = 1'b1;
        end else if (phaseDone) begin
          nextState    = PH_HIGH;
          ctl.loadHigh = 1'b1;
        end
      end
      PH_HIGH: begin
        if (!enable) begin
          nextState = PH_IDLE;
          ctl.clear = 1'b1;
        end else if (phaseDone) begin
          nextState   = PH_LOW;
          ctl.loadLow = 1'b1;
        end
      end
      default: begin
        nextState = PH_IDLE;
        ctl.clear = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= PH_IDLE;
      lowStart  <= 1'b0;
      highStart <= 1'b0;
    end else begin
      state     <= nextState;
      lowStart  <= ctl.loadLow;
      highStart <= ctl.loadHigh;
    end
  end

  assign sclOut = (state != PH_LOW);

  AST_LOW_TO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_LOW && phaseDone && enable) |=> (state == PH_HIGH && highStart)) else $error("low half not followed by high half"); // R9

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(lowStart && highStart)) else $error("both strobes high"); // R8

endmodule

// File: rtl/scl_ratio_div.sv
module scl_ratio_div
  import scl_ratio_div_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] divVal,
  input  logic [1:0]       ratioSel,
  input  logic             slaveMode,
  output logic             sclOut,
  output logic             lowStart,
  output logic             highStart
);

  localparam int CNT_W = DIV_W + 4;

  ctlStrobesT ctl;
  logic       phaseDone;

  scl_ratio_div_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .phaseDone (phaseDone),
    .ctl       (ctl),
    .sclOut    (sclOut),
    .lowStart  (lowStart),
    .highStart (highStart)
  );

  scl_ratio_div_dp #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .divVal    (divVal),
    .ratioSel  (ratioSel),
    .slaveMode (slaveMode),
    .phaseDone (phaseDone)
  );

  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (sclOut && !lowStart && !highStart)) else $error("SCL not released when disabled"); // R7

  AST_FALL_MARKED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOut) |-> lowStart) else $error("SCL fell without low strobe"); // R8

endmodule

// File: tb/scl_ratio_div_bench.sv
module scl_ratio_div_bench;

  localparam int DIV_W = 8;

  typedef struct {
    bit    lvl;
    int    len;
    string tag;
  } phaseItemT;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             enable = 1'b0;
  logic [DIV_W-1:0] divVal = '0;
  logic [1:0]       ratioSel = 2'd0;
  logic             slaveMode = 1'b0;
  logic             sclOut;
  logic             lowStart;
  logic             highStart;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  int lowSeen = 0;
  bit monOn   = 1'b0;
  bit runActive = 1'b0;
  bit runLvl;
  int runLen;
  phaseItemT sb[$];

  always #4 clk = ~clk;  // 125 MHz

  scl_ratio_div #(.DIV_W(DIV_W)) u_scl_ratio_div (
    .clk(clk), .rstN(rstN), .enable(enable), .divVal(divVal),
    .ratioSel(ratioSel), .slaveMode(slaveMode),
    .sclOut(sclOut), .lowStart(lowStart), .highStart(highStart)
  );

  function automatic int benchLowUnits(int code);
    if (code == 1) return 6;
    if (code == 2) return 11;
    return 4;
  endfunction

  function automatic int benchHighUnits(int code);
    return (code == 1 || code == 2) ? 3 : 4;
  endfunction

  function automatic int effDiv(int dv, bit slv);
    return (slv && dv == 0) ? 1 : dv;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic closeRun();
    phaseItemT e;
    if (sb.size() == 0) begin
      check(1'b0, "R9", "unexpected phase, queue empty", runLen, 0);
    end else begin
      e = sb.pop_front();
      check(runLvl == e.lvl, e.tag, "phase level", int'(runLvl), int'(e.lvl));
      check(runLen == e.len, e.tag, "phase length", runLen, e.len);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!monOn) begin
      runActive = 1'b0;
    end else if (lowStart || highStart) begin
      if (runActive) closeRun();
      if (lowStart) begin
        lowSeen++;
        check(sclOut == 1'b0, "R8", "SCL level at low strobe", int'(sclOut), 0);
      end else begin
        check(sclOut == 1'b1, "R8", "SCL level at high strobe", int'(sclOut), 1);
      end
      runActive = 1'b1;
      runLvl    = sclOut;
      runLen    = 1;
    end else if (runActive) begin
      if (sclOut != runLvl)
        check(1'b0, "R9", "SCL changed inside a half", int'(sclOut), int'(runLvl));
      runLen++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      misses++;
      $display("FAIL watchdog expired: actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  task automatic pushPeriod(int code, int dv, bit slv, string tag);
    phaseItemT e;
    int u;
    u = effDiv(dv, slv) + 1;
    e.lvl = 1'b0; e.len = benchLowUnits(code) * u + 2; e.tag = tag;
    sb.push_back(e);
    e.lvl = 1'b1; e.len = benchHighUnits(code) * u + 2;
    sb.push_back(e);
  endtask

  // driver: applies config now (first cycle of a low half); it governs the next n periods
  task automatic runCfg(int code, int dv, bit slv, int n, string tag);
    int target;
    ratioSel  = 2'(code);
    divVal    = DIV_W'(dv);
    slaveMode = slv;
    for (int i = 0; i < n; i++)
      pushPeriod(code, dv, slv, (i == n - 1) ? "R6" : tag);
    target = lowSeen + n;
    wait (lowSeen == target);
    #1;
  endtask

  initial begin
    int target;
    repeat (3) @(negedge clk);
    // reset state (R7)
    check(sclOut == 1'b1, "R7", "SCL in reset", int'(sclOut), 1);
    check(!lowStart && !highStart, "R7", "strobes in reset", int'(lowStart | highStart), 0);
    #1 rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(sclOut == 1'b1, "R7", "SCL while disabled", int'(sclOut), 1);
    #1;
    monOn  = 1'b1;
    enable = 1'b1;
    runCfg(0, 2, 1'b0, 2, "R1");
    runCfg(1, 0, 1'b0, 2, "R2");   // master, divider 0 used as is (R5)
    runCfg(2, 3, 1'b0, 2, "R3");
    runCfg(3, 1, 1'b0, 2, "R4");
    runCfg(0, 0, 1'b1, 2, "R5");
    runCfg(1, 0, 1'b1, 2, "R5");
    runCfg(2, 0, 1'b0, 2, "R3");
    // let the last pushed period's high half close
    target = lowSeen + 1;
    wait (lowSeen == target);
    #1;
    // disable part way through a low half
    monOn = 1'b0;
    repeat (3) @(negedge clk);
    #1 enable = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(sclOut == 1'b1, "R7", "SCL after disable", int'(sclOut), 1);
      check(!lowStart && !highStart, "R7", "strobes after disable", int'(lowStart | highStart), 0);
    end
    check(sb.size() == 0, "R6", "scoreboard drained", sb.size(), 0);
    // re-enable: fresh full-length low half
    #1;
    ratioSel = 2'd2; divVal = DIV_W'(1); slaveMode = 1'b0;
    pushPeriod(2, 1, 1'b0, "R7");
    target  = lowSeen + 2;
    monOn   = 1'b1;
    enable  = 1'b1;
    @(negedge clk);
    check(lowStart == 1'b1, "R7", "low strobe one cycle after enable", int'(lowStart), 1);
    check(sclOut == 1'b0, "R7", "SCL low one cycle after enable", int'(sclOut), 0);
    wait (lowSeen == target);
    #1;
    check(sb.size() == 0, "R7", "scoreboard drained after restart", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule